// File: doc/BRIEF.md
# Two-Counter Event Monitor

This block counts hardware events for software profiling. It holds two programmable counters. Each counter has a select register that names the event code to watch and an 8-bit qualifier mask that chooses which sub-kinds of that event are counted. Every cycle the surrounding core presents one strobe per event code and, for each code, an 8-bit qualifier vector. A counter adds one when the strobe of its code is high and the qualifier shares at least one set bit with its mask.

Both counters start and stop together on one enable bit, and that bit is honoured only in select register 0. Counters are 40 bits wide, but they behave as 32-bit counters: the top eight bits always repeat bit 31. Software usually loads the negative of a sampling period, so crossing out of bit 31 sets a sticky overflow flag and raises an interrupt request. Software clears the flag by writing a one. Some event codes can only be counted on one particular counter. A mask of zero counts nothing, so software can park a counter without touching the global enable.

Top module: `pmu2_top`

## Requirements
- R1: After reset every readable register (addresses 0 to 6) reads zero and `irq` is low, so counting is off.
- R2: Counting on both counters happens only while bit 22 of select register 0 (address 0) is one. Bit 22 of select register 1 (address 1) is stored and read back but has no effect. All 32 bits of both select registers read back as written.
- R3: A write to address 2 (counter 0) or address 4 (counter 1) loads counter bits 31:0 and sets bits 39:32 to copies of bit 31. Address 3 and address 5 read `{24'b0, bits 39:32}` of counter 0 and counter 1. Writes to address 3 and address 5 are ignored.
- R4: Select bits 7:0 hold the event code and bits 15:8 hold the mask. A counter adds exactly one in a cycle where `ev_strobe[code]` is high and `ev_qual[code*8 +: 8] & mask` is nonzero. Both counters may count the same event.
- R5: A mask of zero never counts, for any code including 0x2E, even when the qualifier is 0xFF.
- R6: Codes 0xC1, 0x10, 0x11 and 0x14 count only on counter 0. Codes 0x12 and 0x13 count only on counter 1. If one of these codes is programmed on the other counter, that counter does not count.
- R7: An increment keeps bits 39:32 equal to copies of bit 31. 0x00_7FFF_FFFF steps to 0xFF_8000_0000, and 0xFF_FFFF_FFFF steps to 0x00_0000_0000.
- R8: An increment from either value named in R7 sets the overflow flag of that counter. Bit 0 of address 6 is the flag of counter 0 and bit 1 is the flag of counter 1. `irq` is high while either flag is set. Writing a one to bit n of address 6 clears flag n. An overflow in the same cycle as its clear leaves the flag set.
- R9: If software writes a counter in the same cycle as an event for that counter, the written value is loaded and the event is dropped. The other counter still counts the event.
- R10: A counter takes its new value at the clock edge that samples the event or the write. `reg_rdata` follows `reg_addr` with no clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 select 0, 1 select 1, 2/3 counter 0 low/high, 4/5 counter 1 low/high, 6 overflow flags) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ev_strobe | input | 256 | One strobe per event code for this cycle |
| ev_qual | input | 2048 | 8-bit qualifier per event code, code c at bits c*8+7:c*8 |
| irq | output | 1 | Overflow interrupt request |

## Verification
An event or a write that is presented while the clock is low shows up in the counter right after the next rising edge. The overflow flags and `irq` change at that same edge, because `irq` is formed from the flags with no further register. Reads are combinational, so the bench sets the address and samples one nanosecond later, with the clock steady. It drives every stimulus on a falling edge and reads either before the following rising edge or just after it. The timing test samples both sides of one edge, which shows that the result is due one edge after the stimulus and not two.

// File: rtl/pmu2_pkg.sv
package pmu2_pkg;
  localparam int NCTR      = 2;
  localparam int CODE_W    = 8;
  localparam int MASK_W    = 8;
  localparam int NUM_CODES = 1 << CODE_W;
  localparam int QUAL_W    = NUM_CODES * MASK_W;
  localparam int LO_W      = 32;
  localparam int CTR_W     = 40;
  localparam int HI_W      = CTR_W - LO_W;
  localparam int REG_W     = 32;
  localparam int ADDR_W    = 3;
  localparam int EN_BIT    = 22;
  localparam int CODE_LSB  = 0;
  localparam int MASK_LSB  = CODE_LSB + CODE_W;

  localparam logic [ADDR_W-1:0] A_SEL0 = 3'd0;
  localparam logic [ADDR_W-1:0] A_SEL1 = 3'd1;
  localparam logic [ADDR_W-1:0] A_CLO0 = 3'd2;
  localparam logic [ADDR_W-1:0] A_OVF  = 3'd6;

  function automatic logic [ADDR_W-1:0] lo_addr(input int idx);
    return A_CLO0 + ADDR_W'(2 * idx);
  endfunction

  function automatic logic [ADDR_W-1:0] hi_addr(input int idx);
    return A_CLO0 + ADDR_W'(2 * idx + 1);
  endfunction

  function automatic logic [CODE_W-1:0] sel_code(input logic [REG_W-1:0] sel);
    return sel[CODE_LSB +: CODE_W];
  endfunction

  function automatic logic [MASK_W-1:0] sel_mask(input logic [REG_W-1:0] sel);
    return sel[MASK_LSB +: MASK_W];
  endfunction

  function automatic logic [CTR_W-1:0] sext_lo(input logic [LO_W-1:0] lo);
    return {{HI_W{lo[LO_W-1]}}, lo};
  endfunction

  function automatic logic [CTR_W-1:0] bump(input logic [CTR_W-1:0] ctr);
    logic [LO_W-1:0] nxt;
    nxt = ctr[LO_W-1:0] + {{(LO_W-1){1'b0}}, 1'b1};
    return sext_lo(nxt);
  endfunction

  function automatic logic carry31(input logic [CTR_W-1:0] ctr);
    return &ctr[LO_W-2:0];
  endfunction

  function automatic logic code_allowed(input logic [CODE_W-1:0] code, input int idx);
    case (code)
      8'hC1, 8'h10, 8'h11, 8'h14: return idx == 0;
      8'h12, 8'h13:               return idx == 1;
      default:                    return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/pmu2_match.sv
module pmu2_match
  import pmu2_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic [REG_W-1:0]     sel,
  input  logic [NUM_CODES-1:0] ev_strobe,
  input  logic [QUAL_W-1:0]    ev_qual,
  output logic                 hit
);
  logic [CODE_W-1:0] code;
  logic [MASK_W-1:0] mask;
  logic [MASK_W-1:0] qual;
  logic              strobe;
  logic              qual_ok;
  logic              slot_ok;

  always_comb begin
    code    = sel_code(sel);
    mask    = sel_mask(sel);
    strobe  = ev_strobe[code];
    qual    = ev_qual[int'(code) * MASK_W +: MASK_W];
    qual_ok = |(qual & mask);
    slot_ok = code_allowed(code, IDX);
    hit     = strobe && qual_ok && slot_ok;
  end
endmodule

// File: rtl/pmu2_counter.sv
module pmu2_counter
  import pmu2_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [LO_W-1:0]  wdata,
  input  logic             inc,
  output logic [CTR_W-1:0] ctr,
  output logic             ovf_ev
);
  assign ovf_ev = inc && carry31(ctr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctr <= '0;
    end else if (wr) begin
      ctr <= sext_lo(wdata);
    end else if (inc) begin
      ctr <= bump(ctr);
    end
  end
endmodule

// File: rtl/pmu2_regs.sv
module pmu2_regs
  import pmu2_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_we,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [REG_W-1:0]           reg_wdata,
  output logic [REG_W-1:0]           reg_rdata,
  input  logic [NCTR-1:0][CTR_W-1:0] ctr_q,
  input  logic [NCTR-1:0]            ovf_ev,
  output logic [NCTR-1:0][REG_W-1:0] sel_q,
  output logic [NCTR-1:0]            ctr_wr,
  output logic [NCTR-1:0]            ovf_q
);
  logic            ovf_clr_wr;
  logic [NCTR-1:0] sel_wr;

  assign sel_wr[0]  = reg_we && (reg_addr == A_SEL0);
  assign sel_wr[1]  = reg_we && (reg_addr == A_SEL1);
  assign ovf_clr_wr = reg_we && (reg_addr == A_OVF);

  for (genvar i = 0; i < NCTR; i++) begin : g_slot
    assign ctr_wr[i] = reg_we && (reg_addr == lo_addr(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q[i] <= '0;
      end else if (sel_wr[i]) begin
        sel_q[i] <= reg_wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ovf_q[i] <= 1'b0;
      end else if (ovf_ev[i]) begin
        ovf_q[i] <= 1'b1;
      end else if (ovf_clr_wr && reg_wdata[i]) begin
        ovf_q[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_SEL0) reg_rdata = sel_q[0];
    if (reg_addr == A_SEL1) reg_rdata = sel_q[1];
    if (reg_addr == A_OVF)  reg_rdata = {{(REG_W-NCTR){1'b0}}, ovf_q};
    for (int i = 0; i < NCTR; i++) begin
      if (reg_addr == lo_addr(i)) reg_rdata = ctr_q[i][LO_W-1:0];
      if (reg_addr == hi_addr(i)) reg_rdata = {{(REG_W-HI_W){1'b0}}, ctr_q[i][CTR_W-1:LO_W]};
    end
  end
endmodule

// File: rtl/pmu2_top.sv
module pmu2_top
  import pmu2_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  input  logic [NUM_CODES-1:0] ev_strobe,
  input  logic [QUAL_W-1:0]    ev_qual,
  output logic                 irq
);
  logic [NCTR-1:0][REG_W-1:0] sel_q;
  logic [NCTR-1:0][CTR_W-1:0] ctr_q;
  logic [NCTR-1:0]            ctr_wr;
  logic [NCTR-1:0]            hit;
  logic [NCTR-1:0]            inc_ev;
  logic [NCTR-1:0]            ovf_ev;
  logic [NCTR-1:0]            ovf_q;
  logic                       en_all;

  assign en_all = sel_q[0][EN_BIT];

  pmu2_regs regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ctr_q     (ctr_q),
    .ovf_ev    (ovf_ev),
    .sel_q     (sel_q),
    .ctr_wr    (ctr_wr),
    .ovf_q     (ovf_q)
  );

  for (genvar i = 0; i < NCTR; i++) begin : g_ctr
    pmu2_match #(.IDX(i)) match_i (
      .sel       (sel_q[i]),
      .ev_strobe (ev_strobe),
      .ev_qual   (ev_qual),
      .hit       (hit[i])
    );

    assign inc_ev[i] = hit[i] && en_all && !ctr_wr[i];

    pmu2_counter counter_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (ctr_wr[i]),
      .wdata  (reg_wdata[LO_W-1:0]),
      .inc    (inc_ev[i]),
      .ctr    (ctr_q[i]),
      .ovf_ev (ovf_ev[i])
    );
  end

  assign irq = |ovf_q;
endmodule

// File: rtl/pmu2_chk.sv
module pmu2_chk
  import pmu2_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic              irq,
  input logic [REG_W-1:0]  sel0,
  input logic [REG_W-1:0]  sel1,
  input logic [CTR_W-1:0]  ctr0,
  input logic [CTR_W-1:0]  ctr1,
  input logic [NCTR-1:0]   inc_ev,
  input logic [NCTR-1:0]   ovf_ev
);
  logic wr0;
  logic wr1;
  assign wr0 = reg_we && (reg_addr == 3'd2);
  assign wr1 = reg_we && (reg_addr == 3'd4);

  a_r2_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel0[22] && !wr0 && !wr1) |=> ($stable(ctr0) && $stable(ctr1)));

  a_r3_sext0: assert property (@(posedge clk) disable iff (!rst_n)
    ctr0[39:32] == {8{ctr0[31]}});

  a_r3_sext1: assert property (@(posedge clk) disable iff (!rst_n)
    ctr1[39:32] == {8{ctr1[31]}});

  a_r5_zero_mask: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel0[15:8] == 8'h00) |-> !inc_ev[0]) and ((sel1[15:8] == 8'h00) |-> !inc_ev[1]));

  a_r6_slot0_only: assert property (@(posedge clk) disable iff (!rst_n)
    (sel1[7:0] inside {8'hC1, 8'h10, 8'h11, 8'h14}) |-> !inc_ev[1]);

  a_r6_slot1_only: assert property (@(posedge clk) disable iff (!rst_n)
    (sel0[7:0] inside {8'h12, 8'h13}) |-> !inc_ev[0]);

  a_r7_step0: assert property (@(posedge clk) disable iff (!rst_n)
    inc_ev[0] |=> (ctr0[31:0] == $past(ctr0[31:0]) + 32'd1));

  a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|ovf_ev));

  a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr0 |=> (ctr0[31:0] == $past(reg_wdata)));
endmodule

bind pmu2_top pmu2_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .irq       (irq),
  .sel0      (sel_q[0]),
  .sel1      (sel_q[1]),
  .ctr0      (ctr_q[0]),
  .ctr1      (ctr_q[1]),
  .inc_ev    (inc_ev),
  .ovf_ev    (ovf_ev)
);

// File: tb/pmu2_tb.sv
`timescale 1ns/1ps
module pmu2_top_tb_top;
  localparam logic [31:0] EN = 32'h0040_0000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [255:0]  ev_strobe = '0;
  logic [2047:0] ev_qual = '0;
  logic          irq;
  int            n_vec = 0;
  int            n_bad = 0;
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  pmu2_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_strobe(ev_strobe),
    .ev_qual(ev_qual), .irq(irq)
  );

  function automatic logic [31:0] selv(input logic en, input logic [7:0] mask, input logic [7:0] code);
    return (en ? EN : 32'h0) | {16'h0, mask, code};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic rd_ctr(input int idx, output logic [39:0] v);
    logic [31:0] lo, hi;
    rd(3'(2 + 2 * idx), lo);
    rd(3'(3 + 2 * idx), hi);
    v = {hi[7:0], lo};
  endtask

  task automatic set_ev(input int code, input logic [7:0] q);
    ev_strobe = '0; ev_qual = '0;
    ev_strobe[code] = 1'b1;
    ev_qual[code*8 +: 8] = q;
  endtask

  task automatic clr_ev();
    ev_strobe = '0; ev_qual = '0;
  endtask

  task automatic pulse(input int code, input logic [7:0] q);
    @(negedge clk);
    set_ev(code, q);
    @(negedge clk);
    clr_ev();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), d);
      check("R1 reset register", {32'h0, d}, 64'h0);
    end
    check("R1 reset irq", {63'h0, irq}, 64'h0);
  endtask

  task automatic t_enable();
    logic [39:0] c0, c1;
    logic [31:0] d;
    wr(3'd0, selv(1'b0, 8'hFF, 8'h79));
    wr(3'd1, selv(1'b1, 8'h01, 8'h79));
    pulse(8'h79, 8'hFF);
    rd_ctr(0, c0); rd_ctr(1, c1);
    check("R2 off counter0", {24'h0, c0}, 64'h0);
    check("R2 sel1 enable ignored", {24'h0, c1}, 64'h0);
    rd(3'd1, d);
    check("R2 sel1 readback", {32'h0, d}, {32'h0, selv(1'b1, 8'h01, 8'h79)});
    wr(3'd0, selv(1'b1, 8'hFF, 8'h79));
    for (int k = 0; k < 3; k++) pulse(8'h79, 8'h01);
    rd_ctr(0, c0); rd_ctr(1, c1);
    check("R4 counter0 three events", {24'h0, c0}, 64'd3);
    check("R4 counter1 same events", {24'h0, c1}, 64'd3);
  endtask

  task automatic t_match();
    logic [39:0] c0, c1;
    wr(3'd2, 32'h0); wr(3'd4, 32'h0);
    wr(3'd0, selv(1'b1, 8'h0F, 8'h2E));
    wr(3'd1, selv(1'b0, 8'h01, 8'h2E));
    pulse(8'h2E, 8'h02);
    pulse(8'h79, 8'hFF);
    pulse(8'h2E, 8'h81);
    rd_ctr(0, c0); rd_ctr(1, c1);
    check("R4 mask 0F subset", {24'h0, c0}, 64'd2);
    check("R4 mask 01 subset", {24'h0, c1}, 64'd1);
  endtask

  task automatic t_park();
    logic [39:0] c1;
    wr(3'd4, 32'h0);
    wr(3'd1, selv(1'b0, 8'h00, 8'h2E));
    pulse(8'h2E, 8'hFF);
    pulse(8'h2E, 8'h0F);
    rd_ctr(1, c1);
    check("R5 zero mask parks counter1", {24'h0, c1}, 64'h0);
  endtask

  task automatic t_restrict();
    logic [39:0] c0, c1;
    wr(3'd2, 32'h0); wr(3'd4, 32'h0);
    wr(3'd0, selv(1'b1, 8'hFF, 8'h12));
    wr(3'd1, selv(1'b0, 8'hFF, 8'h12));
    pulse(8'h12, 8'hFF);
    rd_ctr(0, c0); rd_ctr(1, c1);
    check("R6 code 12 blocked on counter0", {24'h0, c0}, 64'h0);
    check("R6 code 12 on counter1", {24'h0, c1}, 64'd1);
    wr(3'd0, selv(1'b1, 8'hFF, 8'hC1));
    wr(3'd1, selv(1'b0, 8'hFF, 8'hC1));
    pulse(8'hC1, 8'hFF);
    rd_ctr(0, c0); rd_ctr(1, c1);
    check("R6 code C1 on counter0", {24'h0, c0}, 64'd1);
    check("R6 code C1 blocked on counter1", {24'h0, c1}, 64'd1);
  endtask

  task automatic t_sext();
    logic [39:0] c0;
    wr(3'd2, 32'h8000_0000);
    rd_ctr(0, c0);
    check("R3 negative load", {24'h0, c0}, 64'hFF_8000_0000);
    wr(3'd3, 32'h0000_0012);
    rd_ctr(0, c0);
    check("R3 high write ignored", {24'h0, c0}, 64'hFF_8000_0000);
    wr(3'd2, 32'h7FFF_FFFF);
    rd_ctr(0, c0);
    check("R3 positive load", {24'h0, c0}, 64'h00_7FFF_FFFF);
  endtask

  task automatic t_wrap();
    logic [39:0] c0, c1;
    logic [31:0] d;
    wr(3'd0, selv(1'b1, 8'hFF, 8'h79));
    wr(3'd1, selv(1'b0, 8'hFF, 8'h79));
    wr(3'd2, 32'h7FFF_FFFF);
    wr(3'd4, 32'hFFFF_FFFE);
    pulse(8'h79, 8'h01);
    rd_ctr(0, c0); rd_ctr(1, c1);
    check("R7 cross into negative", {24'h0, c0}, 64'hFF_8000_0000);
    check("R7 plain negative step", {24'h0, c1}, 64'hFF_FFFF_FFFF);
    rd(3'd6, d);
    check("R8 flag0 set", {32'h0, d}, 64'h1);
    check("R8 irq high", {63'h0, irq}, 64'h1);
    wr(3'd6, 32'h1);
    rd(3'd6, d);
    check("R8 flag0 cleared", {32'h0, d}, 64'h0);
    check("R8 irq low", {63'h0, irq}, 64'h0);
    wr(3'd0, selv(1'b1, 8'hFF, 8'h2E));
    pulse(8'h79, 8'h01);
    rd_ctr(1, c1);
    check("R7 wrap to zero", {24'h0, c1}, 64'h0);
    rd(3'd6, d);
    check("R8 flag1 set", {32'h0, d}, 64'h2);
    wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd0, selv(1'b1, 8'hFF, 8'h79));
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd6; reg_wdata = 32'h1;
    set_ev(8'h79, 8'h01);
    @(negedge clk);
    reg_we = 1'b0; clr_ev();
    rd(3'd6, d);
    check("R8 set wins over clear", {32'h0, d}, 64'h3);
    wr(3'd6, 32'h3);
    check("R8 irq after full clear", {63'h0, irq}, 64'h0);
  endtask

  task automatic t_priority();
    logic [39:0] c0, c1;
    wr(3'd0, selv(1'b1, 8'hFF, 8'h79));
    wr(3'd1, selv(1'b0, 8'hFF, 8'h79));
    wr(3'd2, 32'd5);
    wr(3'd4, 32'd7);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = 32'd100;
    set_ev(8'h79, 8'hFF);
    @(negedge clk);
    reg_we = 1'b0; clr_ev();
    rd_ctr(0, c0); rd_ctr(1, c1);
    check("R9 write beats event", {24'h0, c0}, 64'd100);
    check("R9 other counter counts", {24'h0, c1}, 64'd8);
  endtask

  task automatic t_timing();
    wr(3'd0, selv(1'b1, 8'hFF, 8'h79));
    wr(3'd2, 32'd0);
    reg_addr = 3'd2;
    @(negedge clk);
    set_ev(8'h79, 8'h01);
    #1;
    check("R10 before edge", {32'h0, reg_rdata}, 64'd0);
    @(posedge clk);
    #1;
    check("R10 after edge", {32'h0, reg_rdata}, 64'd1);
    @(negedge clk);
    clr_ev();
    reg_addr = 3'd6;
    #1;
    check("R10 read follows address", {32'h0, reg_rdata}, 64'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enable();
    t_match();
    t_park();
    t_restrict();
    t_sext();
    t_wrap();
    t_priority();
    t_timing();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1'b1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule